// File: doc/BRIEF.md
# Answer-to-Reset Convention Detector and Converter

This stage sits on the receive path of a smart card interface, between the character receiver and the byte interface read by firmware. After each session start it treats the next received character as the initial, convention-selecting character. That character tells the stage whether the card signals in direct or in inverse convention. The stage keeps that decision until the next session start.

In inverse convention the stage rewrites every character, the initial one included, so that the consumer sees only direct-convention values. The rewrite can be switched off, and then raw bytes pass through unchanged. Every character gets a parity check, using the complemented parity bit in inverse convention. A parity failure on the initial character also raises a break request, and a control input turns off both the check and the break for that character. An initial character that matches neither known pattern is flagged and handled as direct.

Top module: `atr_conv_top`

## Requirements
- R1: After reset, and in the cycle after a session-start pulse, the convention is undetermined: `conv_inv` = 0 and `ts_invalid` = 0. After reset, `out_valid`, `par_err` and `brk_req` are also 0.
- R2: The first character accepted after a session start selects the convention. Raw 0x3B selects direct (`conv_inv` = 0) and raw 0x03 selects inverse (`conv_inv` = 1). `conv_inv` is updated in the same cycle as that character's `out_valid` and holds until the next session start.
- R3: In inverse convention with `conv_en` = 1, output bit i equals the complement of raw bit (7 - i). The initial raw 0x03 is therefore delivered as 0x3F.
- R4: With `conv_en` = 0, `out_data` equals the raw byte for every character, in either convention.
- R5: Parity is even over the 8 data bits plus the parity bit. In direct convention `par_err` = 1 when the raw 9 bits hold an odd number of ones. In inverse convention the check runs on the complemented bits, so `par_err` = 1 when the raw 9 bits hold an even number of ones.
- R6: For the initial character, `par_err` and `brk_req` are both 1 when the parity check fails and `ts_chk_en` = 1. With `ts_chk_en` = 0 both are 0. `brk_req` is never 1 for any later character.
- R7: An initial character other than 0x3B or 0x03 sets `ts_invalid` = 1, which holds until the next session start. The convention stays direct, the byte is delivered unchanged, and its parity is checked as direct.
- R8: `out_valid` is 1 for exactly one cycle, the clock after each accepted `rx_valid`. `par_err` and `brk_req` are 0 whenever `out_valid` is 0.
- R9: A character whose `rx_valid` coincides with `sess_start` is dropped and produces no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Pulse: begin a new card session |
| rx_valid | input | 1 | Raw character strobe |
| rx_data | input | DATA_W | Raw character data bits |
| rx_par | input | 1 | Raw parity bit |
| conv_en | input | 1 | Enable inverse-to-direct rewrite |
| ts_chk_en | input | 1 | Enable parity check and break on the initial character |
| out_valid | output | 1 | Converted character strobe |
| out_data | output | DATA_W | Converted character |
| conv_inv | output | 1 | 1 when inverse convention has been detected |
| par_err | output | 1 | Parity failure for the delivered character |
| brk_req | output | 1 | Break (error signal) request for the initial character |
| ts_invalid | output | 1 | Initial character matched neither pattern |

## Verification
Every result of a character arrives one clock after its input strobe: the byte, both error flags, and the updated `conv_inv` and `ts_invalid`. The bench drives a strobe on a falling edge and removes it on the next falling edge. At that same falling edge a monitor compares the output against the item the driver queued. The cleared convention is sampled one falling edge after the session-start pulse. A character dropped by a coinciding session start must leave the queue untouched, and any unexpected strobe counts as a failure.

// File: rtl/atr_pkg.sv
// Package: shared types and helpers for the convention detector.
// Assumes characters are at most 32 bits wide.
package atr_pkg;

    // Convention state of the current session.
    typedef enum logic [1:0] {
        CONV_UNK = 2'd0,
        CONV_DIR = 2'd1,
        CONV_INV = 2'd2
    } conv_t;

    // Classification result for an initial character.
    typedef struct packed {
        logic is_dir;
        logic is_inv;
    } ts_class_t;

endpackage

// File: rtl/atr_ts_classify.sv
// Classifies a raw character against the direct and inverse initial
// patterns. Purely combinational; assumes both patterns differ.
module atr_ts_classify
    import atr_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] TS_DIRECT  = 8'h3B,
    parameter logic [DATA_W-1:0] TS_INVERSE = 8'h03
) (
    input  logic [DATA_W-1:0] raw,
    output ts_class_t         cls
);

    // Compare the raw pattern against both known initial characters.
    always_comb begin
        cls.is_dir = (raw == TS_DIRECT);
        cls.is_inv = (raw == TS_INVERSE);
    end

endmodule

// File: rtl/atr_xform.sv
// Bit transform: when inv_en is set each output bit is the complement of
// the mirrored input bit, otherwise data passes unchanged.
module atr_xform #(
    parameter int DATA_W = 8
) (
    input  logic              inv_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Select mirrored-complemented or straight bit.
        always_comb begin
            dout[i] = inv_en ? ~din[DATA_W-1-i] : din[i];
        end
    end

endmodule

// File: rtl/atr_parity.sv
// Even-parity checker over data plus parity bit. In inverse convention
// the check is made on the complemented bits.
module atr_parity #(
    parameter int DATA_W = 8
) (
    input  logic              inv,
    input  logic [DATA_W-1:0] din,
    input  logic              par,
    output logic              err
);

    localparam int NBITS = DATA_W + 1;

    logic [NBITS-1:0] word;

    // Form the checked word in the active convention.
    always_comb begin
        word = inv ? ~{par, din} : {par, din};
    end

    // Odd count of ones is a failure.
    always_comb begin
        err = ^word;
    end

endmodule

// File: rtl/atr_conv_top.sv
// Convention detector and converter. The first accepted character after
// a session start selects the convention; all characters are rewritten
// and parity checked one clock after their strobe. Assumes no character
// arrives before the initial one is meant to. Synchronous active-low reset.
module atr_conv_top
    import atr_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] TS_DIRECT  = 8'h3B,
    parameter logic [DATA_W-1:0] TS_INVERSE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              conv_en,
    input  logic              ts_chk_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              conv_inv,
    output logic              par_err,
    output logic              brk_req,
    output logic              ts_invalid
);

    conv_t             state_q;
    ts_class_t         cls;
    logic              first_chr;
    logic              accept;
    logic              eff_inv;
    logic              perr_raw;
    logic              perr_flag;
    logic              brk_flag;
    logic [DATA_W-1:0] conv_data;
    logic              ts_inv_q;

    atr_ts_classify #(
        .DATA_W    (DATA_W),
        .TS_DIRECT (TS_DIRECT),
        .TS_INVERSE(TS_INVERSE)
    ) i_cls (
        .raw(rx_data),
        .cls(cls)
    );

    // Decide acceptance and the convention in force for this character.
    always_comb begin
        first_chr = (state_q == CONV_UNK);
        accept    = rx_valid && !sess_start;
        eff_inv   = first_chr ? cls.is_inv : (state_q == CONV_INV);
    end

    atr_xform #(.DATA_W(DATA_W)) i_xf (
        .inv_en(eff_inv && conv_en),
        .din   (rx_data),
        .dout  (conv_data)
    );

    atr_parity #(.DATA_W(DATA_W)) i_par (
        .inv(eff_inv),
        .din(rx_data),
        .par(rx_par),
        .err(perr_raw)
    );

    // Gate parity and break for the initial character.
    always_comb begin
        perr_flag = first_chr ? (perr_raw && ts_chk_en) : perr_raw;
        brk_flag  = first_chr && perr_raw && ts_chk_en;
    end

    // Convention state: cleared by session start, set by initial char.
    always_ff @(posedge clk) begin
        if (!rst_n || sess_start) begin
            state_q  <= CONV_UNK;
            ts_inv_q <= 1'b0;
        end else if (accept && first_chr) begin
            state_q  <= cls.is_inv ? CONV_INV : CONV_DIR;
            ts_inv_q <= !cls.is_inv && !cls.is_dir;
        end
    end

    // Output register stage: one clock after each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            par_err   <= 1'b0;
            brk_req   <= 1'b0;
        end else begin
            out_valid <= accept;
            par_err   <= accept && perr_flag;
            brk_req   <= accept && brk_flag;
            if (accept) begin
                out_data <= conv_data;
            end
        end
    end

    // Drive flag outputs from state.
    always_comb begin
        conv_inv   = (state_q == CONV_INV);
        ts_invalid = ts_inv_q;
    end

    // R8: an accepted strobe produces a strobe one clock later.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !sess_start) |=> out_valid);

    // R8: no strobe without an accepted input the clock before.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !out_valid);

    // R9: a character coinciding with session start is dropped.
    a_r9_sess_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sess_start) |=> !out_valid);

    // R1: session start clears the convention flags.
    a_r1_sess_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sess_start |=> (!conv_inv && !ts_invalid));

    // R2: convention holds while no character or session start arrives.
    a_r2_conv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sess_start && !rx_valid) |=> $stable(conv_inv));

    // R6: a break request always comes with a flagged character.
    a_r6_brk_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (out_valid && par_err));

    // R7: an invalid initial character leaves the convention direct.
    a_r7_invalid_direct: assert property (@(posedge clk) disable iff (!rst_n)
        ts_invalid |-> !conv_inv);

endmodule

// File: tb/test_atr_conv_top.sv
// Scoreboard bench: the driver queues expected results, the monitor pops
// and compares them on every output strobe.
module test_atr_conv_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sess_start;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_par;
    logic       conv_en;
    logic       ts_chk_en;
    logic       out_valid;
    logic [7:0] out_data;
    logic       conv_inv;
    logic       par_err;
    logic       brk_req;
    logic       ts_invalid;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    // Expected item: {data, par_err, brk_req, conv_inv, ts_invalid}.
    logic [11:0] exp_q[$];

    // Bench model of the session state.
    logic m_known;
    logic m_inv;
    logic m_bad;

    atr_conv_top i_atr_conv_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .sess_start(sess_start),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_par    (rx_par),
        .conv_en   (conv_en),
        .ts_chk_en (ts_chk_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .conv_inv  (conv_inv),
        .par_err   (par_err),
        .brk_req   (brk_req),
        .ts_invalid(ts_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones9(input logic [7:0] d, input logic p);
        int n = 0;
        for (int i = 0; i < 8; i++) n += d[i];
        return n + p;
    endfunction

    function automatic logic [7:0] mirror_inv(input logic [7:0] d);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = ~d[7-i];
        return o;
    endfunction

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Monitor: compare each output strobe with the queued item (R8).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R8 unexpected strobe actual=%h expected=none", out_data);
            end else begin
                check("R2-R7 result", {out_data, par_err, brk_req, conv_inv, ts_invalid},
                      exp_q.pop_front());
            end
        end
    end

    task automatic sess();
        sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
        m_known = 1'b0; m_inv = 1'b0; m_bad = 1'b0;
        // R1: convention cleared one clock after the pulse.
        check("R1 session clear", {10'd0, conv_inv, ts_invalid}, 12'd0);
    endtask

    // Driver: compute expected result from the requirements, then send.
    task automatic send(input logic [7:0] d, input logic p);
        logic       first = !m_known;
        logic       inv;
        logic       perr;
        logic [7:0] od;
        if (first) begin
            m_known = 1'b1;
            m_inv   = (d == 8'h03);
            m_bad   = (d != 8'h03) && (d != 8'h3B);
        end
        inv  = m_inv;
        perr = inv ? (ones9(d, p) % 2 == 0) : (ones9(d, p) % 2 == 1);
        od   = (inv && conv_en) ? mirror_inv(d) : d;
        exp_q.push_back({od, first ? (perr && ts_chk_en) : perr,
                         first && perr && ts_chk_en, inv, m_bad});
        rx_valid = 1'b1; rx_data = d; rx_par = p;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Good-parity helpers for each convention.
    function automatic logic par_dir(input logic [7:0] d);
        return ^d;
    endfunction
    function automatic logic par_inv(input logic [7:0] d);
        return ~(^d);
    endfunction

    initial begin
        rst_n = 1'b0; sess_start = 1'b0; rx_valid = 1'b0;
        rx_data = '0; rx_par = 1'b0; conv_en = 1'b1; ts_chk_en = 1'b1;
        m_known = 1'b0; m_inv = 1'b0; m_bad = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 reset", {8'd0, out_valid, par_err, brk_req, conv_inv}, 12'd0);
        check("R1 reset ts", {11'd0, ts_invalid}, 12'd0);

        // R2 direct session, R5 direct parity good and bad.
        sess();
        send(8'h3B, par_dir(8'h3B));
        send(8'h12, par_dir(8'h12));
        send(8'hA5, ~par_dir(8'hA5));
        send(8'hFF, par_dir(8'hFF));
        check("R2 direct held", {11'd0, conv_inv}, 12'd0);

        // R2/R3 inverse session with conversion, R5 inverse parity.
        sess();
        send(8'h03, par_inv(8'h03));
        check("R2 inverse held", {11'd0, conv_inv}, 12'd1);
        send(8'h80, par_inv(8'h80));
        send(8'h5C, ~par_inv(8'h5C));
        send(8'h00, par_inv(8'h00));
        // Back-to-back characters.
        rx_valid = 1'b0;
        send(8'hC3, par_inv(8'hC3));
        send(8'h3B, par_inv(8'h3B));

        // R4 inverse session with conversion off.
        conv_en = 1'b0;
        sess();
        send(8'h03, par_inv(8'h03));
        send(8'h81, par_inv(8'h81));
        send(8'h81, ~par_inv(8'h81));
        conv_en = 1'b1;

        // R6 bad initial parity with checking on: error and break.
        sess();
        send(8'h3B, ~par_dir(8'h3B));
        send(8'h44, ~par_dir(8'h44));
        // R6 bad initial parity with checking off: neither.
        ts_chk_en = 1'b0;
        sess();
        send(8'h03, ~par_inv(8'h03));
        send(8'h10, ~par_inv(8'h10));
        ts_chk_en = 1'b1;
        sess();
        send(8'h03, ~par_inv(8'h03));

        // R7 invalid initial character, good and bad parity.
        sess();
        send(8'h55, par_dir(8'h55));
        send(8'h03, par_dir(8'h03));
        check("R7 invalid held", {10'd0, conv_inv, ts_invalid}, 12'd1);
        sess();
        send(8'h3F, ~par_dir(8'h3F));

        // R9 character coinciding with session start is dropped.
        sess_start = 1'b1; rx_valid = 1'b1; rx_data = 8'h03; rx_par = par_inv(8'h03);
        @(negedge clk);
        sess_start = 1'b0; rx_valid = 1'b0;
        m_known = 1'b0; m_inv = 1'b0; m_bad = 1'b0;
        check("R9 dropped", {10'd0, out_valid, conv_inv}, 12'd0);
        send(8'h3B, par_dir(8'h3B));

        repeat (3) @(negedge clk);
        check("R8 queue drained", 12'(exp_q.size()), 12'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule